// File: doc/BRIEF.md
# Address and Next-PC Generator

This block is the combinational address path of a 16-bit, word-addressed processor. One adder adds one of two base values to one of three offset choices. The base is the incremented PC or a register value. The offset is zero, a sign-extended 6-bit field or a sign-extended 9-bit field of the instruction word. The sum is the effective address. A load-effective-address operation writes it to a register, and it also feeds the memory address register and the program counter.

A branch test compares the three condition-mask bits of the instruction with the current negative, zero and positive flags. Two selectors are driven by the controller. The MAR selector chooses the effective address or the zero-extended 8-bit trap vector. The PC selector chooses the incremented PC, a conditional branch target, the adder output (register jump) or the value on the shared bus (trap). Indirect accesses are not handled here: the controller issues the second memory read using the address this block forms.

Top module: `agu_top`

## Requirements
- R1: With `base_sel`=0 and `off_sel`=2, `eff_addr` equals `pc_inc` plus `ir[8:0]` sign-extended to 16 bits.
- R2: With `base_sel`=1 and `off_sel`=1, `eff_addr` equals `base_val` plus `ir[5:0]` sign-extended to 16 bits.
- R3: With `off_sel`=0 or 3, the offset is zero, so `eff_addr` equals the selected base (`pc_inc` when `base_sel`=0, `base_val` when `base_sel`=1).
- R4: With `mar_sel`=1, `mar_next` is `ir[7:0]` zero-extended to 16 bits. With `mar_sel`=0, `mar_next` equals `eff_addr`.
- R5: `br_taken` is 1 exactly when a mask bit and its flag are both 1. The pairs are `ir[11]` with `flag_n`, `ir[10]` with `flag_z`, and `ir[9]` with `flag_p`.
- R6: Mask `ir[11:9]`=000 never gives a taken branch. Mask 111 gives a taken branch whenever any flag is set.
- R7: With `pc_sel`=0, `pc_next` equals `pc_inc`.
- R8: With `pc_sel`=1, `pc_next` equals `eff_addr` when `br_taken` is 1, and `pc_inc` otherwise.
- R9: With `pc_sel`=2, `pc_next` equals `eff_addr` unconditionally. With `off_sel`=0 and `base_sel`=1, this is the full register value (jump to any address).
- R10: With `pc_sel`=3, `pc_next` equals `bus_val`.
- R11: Address sums wrap modulo 2^16. For example, `pc_inc`=16'h0000 plus offset -1 gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter after the fetch increment |
| base_val | input | 16 | Value of the base/jump register |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_p | input | 1 | Positive condition flag |
| bus_val | input | 16 | Value on the shared data bus |
| base_sel | input | 1 | Adder base: 0 = pc_inc, 1 = base_val |
| off_sel | input | 2 | Adder offset: 0 = zero, 1 = 6-bit signed, 2 = 9-bit signed, 3 = zero |
| mar_sel | input | 1 | MAR source: 0 = effective address, 1 = trap vector |
| pc_sel | input | 2 | PC source: 0 = pc_inc, 1 = branch, 2 = adder, 3 = bus |
| eff_addr | output | 16 | Effective address (adder sum) |
| mar_next | output | 16 | Value for the memory address register |
| br_taken | output | 1 | Branch condition satisfied |
| pc_next | output | 16 | Selected next program counter |

## Verification
The block has no state, so a fault in its internal muxes or sign-extension shows at the ports in the same cycle the inputs are applied. A wrong offset extension gives addresses that are correct for small positive offsets and wrong for negative ones, so the stimulus weights the offset sign bits. A wrong flag-to-mask pairing changes `br_taken` only for some single-flag patterns, so every mask value is crossed with every single flag. A PC mux fault shows up as `pc_next` copying the wrong source for one selector code.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the address and next-PC generator.
// Assumes the controller drives the selector codes listed here.
package agu_pkg;
    typedef enum logic {
        BASE_PC  = 1'b0,
        BASE_REG = 1'b1
    } base_sel_e;

    typedef enum logic [1:0] {
        OFF_NONE  = 2'd0,
        OFF_SHORT = 2'd1,
        OFF_LONG  = 2'd2,
        OFF_RSVD  = 2'd3
    } off_sel_e;

    typedef enum logic {
        MAR_FROM_SUM = 1'b0,
        MAR_FROM_VEC = 1'b1
    } mar_sel_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_COND   = 2'd1,
        NPC_SUM    = 2'd2,
        NPC_BUS    = 2'd3
    } pc_sel_e;
endpackage

// File: rtl/agu_offset_mux.sv
// Module: agu_offset_mux
// Builds the adder's offset operand from the instruction word: zero, a
// sign-extended short field or a sign-extended long field.
// Assumes both fields sit at bit 0 of the instruction word.
module agu_offset_mux
    import agu_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 6,
    parameter int LONG_W  = 9
) (
    input  logic [WORD_W-1:0] ir,
    input  off_sel_e          sel,
    output logic [WORD_W-1:0] offset
);
    localparam int N_EXT = 2;
    localparam int EXT_W [N_EXT] = '{SHORT_W, LONG_W};

    logic [WORD_W-1:0] ext [N_EXT];

    // One sign-extender per field width.
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        localparam int FW = EXT_W[g];
        assign ext[g] = {{(WORD_W-FW){ir[FW-1]}}, ir[FW-1:0]};
    end

    // Pick the offset; the spare code reads as zero.
    always_comb begin
        unique case (sel)
            OFF_SHORT: offset = ext[0];
            OFF_LONG:  offset = ext[1];
            default:   offset = '0;
        endcase
    end
endmodule

// File: rtl/agu_branch_eval.sv
// Module: agu_branch_eval
// Decides whether a conditional branch is taken: any mask bit whose
// matching flag is set. Mask order is {negative, zero, positive}.
// Assumes the flags are already registered by the controller.
module agu_branch_eval #(
    parameter int N_COND = 3
) (
    input  logic [N_COND-1:0] mask,
    input  logic [N_COND-1:0] flags,
    output logic              taken
);
    logic [N_COND-1:0] hit;

    // Per-condition match.
    for (genvar g = 0; g < N_COND; g++) begin : g_hit
        assign hit[g] = mask[g] & flags[g];
    end

    // Any match takes the branch.
    always_comb taken = |hit;
endmodule

// File: rtl/agu_pc_mux.sv
// Module: agu_pc_mux
// Chooses the next program counter among the sequential value, a
// conditional target, the adder sum and the bus.
// Assumes a not-taken branch keeps the sequential value.
module agu_pc_mux
    import agu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  pc_sel_e           sel,
    input  logic              taken,
    input  logic [WORD_W-1:0] seq_pc,
    input  logic [WORD_W-1:0] sum,
    input  logic [WORD_W-1:0] bus,
    output logic [WORD_W-1:0] npc
);
    // Next-PC source selection.
    always_comb begin
        unique case (sel)
            NPC_SEQ:  npc = seq_pc;
            NPC_COND: npc = taken ? sum : seq_pc;
            NPC_SUM:  npc = sum;
            NPC_BUS:  npc = bus;
            default:  npc = seq_pc;
        endcase
    end
endmodule

// File: rtl/agu_top.sv
// Module: agu_top
// Combinational address path: one adder (base + offset), the MAR source
// mux, the branch test and the next-PC mux.
// Assumes word addressing; all sums wrap modulo 2^WORD_W. The block has no
// storage, so it takes no clock or reset.
module agu_top
    import agu_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SHORT_W = 6,
    parameter int LONG_W  = 9,
    parameter int VEC_W   = 8,
    parameter int COND_LSB = 9
) (
    input  logic [15:0] ir,
    input  logic [15:0] pc_inc,
    input  logic [15:0] base_val,
    input  logic        flag_n,
    input  logic        flag_z,
    input  logic        flag_p,
    input  logic [15:0] bus_val,
    input  logic        base_sel,
    input  logic [1:0]  off_sel,
    input  logic        mar_sel,
    input  logic [1:0]  pc_sel,
    output logic [15:0] eff_addr,
    output logic [15:0] mar_next,
    output logic        br_taken,
    output logic [15:0] pc_next
);
    localparam int N_COND = 3;

    logic [WORD_W-1:0] base_op;
    logic [WORD_W-1:0] off_op;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] vec_ext;

    // Adder base operand.
    always_comb base_op = (base_sel_e'(base_sel) == BASE_REG) ? base_val : pc_inc;

    agu_offset_mux #(
        .WORD_W (WORD_W),
        .SHORT_W(SHORT_W),
        .LONG_W (LONG_W)
    ) u_off (
        .ir    (ir),
        .sel   (off_sel_e'(off_sel)),
        .offset(off_op)
    );

    // Address adder, wraps at the word width.
    always_comb sum = base_op + off_op;

    // Trap vector, zero-extended.
    always_comb vec_ext = {{(WORD_W-VEC_W){1'b0}}, ir[VEC_W-1:0]};

    // MAR source selection.
    always_comb mar_next = (mar_sel_e'(mar_sel) == MAR_FROM_VEC) ? vec_ext : sum;

    agu_branch_eval #(
        .N_COND(N_COND)
    ) u_br (
        .mask (ir[COND_LSB +: N_COND]),
        .flags({flag_n, flag_z, flag_p}),
        .taken(br_taken)
    );

    agu_pc_mux #(
        .WORD_W(WORD_W)
    ) u_pc (
        .sel   (pc_sel_e'(pc_sel)),
        .taken (br_taken),
        .seq_pc(pc_inc),
        .sum   (sum),
        .bus   (bus_val),
        .npc   (pc_next)
    );

    assign eff_addr = sum;
endmodule

// File: rtl/agu_checker.sv
// Module: agu_checker
// Port-level checks on the address path, attached to agu_top by bind.
// Assumes inputs settle before the combinational checks are evaluated.
module agu_checker (
    input logic [15:0] ir,
    input logic [15:0] pc_inc,
    input logic [15:0] base_val,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_p,
    input logic [15:0] bus_val,
    input logic        base_sel,
    input logic [1:0]  off_sel,
    input logic        mar_sel,
    input logic [1:0]  pc_sel,
    input logic [15:0] eff_addr,
    input logic [15:0] mar_next,
    input logic        br_taken,
    input logic [15:0] pc_next
);
    // Immediate checks on the settled port values.
    always_comb begin
        if (!base_sel && off_sel == 2'd2)
            AST_PCREL_SUM: assert (eff_addr == 16'(pc_inc + {{7{ir[8]}}, ir[8:0]}));  // R1
        if (base_sel && off_sel == 2'd1)
            AST_BASE_SUM: assert (eff_addr == 16'(base_val + {{10{ir[5]}}, ir[5:0]}));  // R2
        if (off_sel == 2'd0 || off_sel == 2'd3)
            AST_ZERO_OFF: assert (eff_addr == (base_sel ? base_val : pc_inc));  // R3
        if (mar_sel)
            AST_MAR_VEC: assert (mar_next == {8'h00, ir[7:0]});  // R4
        else
            AST_MAR_SUM: assert (mar_next == eff_addr);  // R4
        if (ir[11:9] == 3'b000)
            AST_BR_NEVER: assert (!br_taken);  // R6
        if (ir[11:9] == 3'b111 && (flag_n || flag_z || flag_p))
            AST_BR_ALWAYS: assert (br_taken);  // R6
        if (pc_sel == 2'd0)
            AST_PC_SEQ: assert (pc_next == pc_inc);  // R7
        if (pc_sel == 2'd1)
            AST_PC_COND: assert (pc_next == (br_taken ? eff_addr : pc_inc));  // R8
        if (pc_sel == 2'd2)
            AST_PC_SUM: assert (pc_next == eff_addr);  // R9
        if (pc_sel == 2'd3)
            AST_PC_BUS: assert (pc_next == bus_val);  // R10
    end
endmodule

bind agu_top agu_checker u_agu_checker (.*);

// File: tb/agu_top_tb_top.sv
// Bench: directed corners plus seeded random stimulus, checked against a
// model built from the requirements.
module agu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ir, pc_inc, base_val, bus_val;
    logic        flag_n, flag_z, flag_p, base_sel, mar_sel;
    logic [1:0]  off_sel, pc_sel;
    logic [15:0] eff_addr, mar_next, pc_next;
    logic        br_taken;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    agu_top dut_i (
        .ir(ir), .pc_inc(pc_inc), .base_val(base_val),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .bus_val(bus_val), .base_sel(base_sel), .off_sel(off_sel),
        .mar_sel(mar_sel), .pc_sel(pc_sel),
        .eff_addr(eff_addr), .mar_next(mar_next),
        .br_taken(br_taken), .pc_next(pc_next)
    );

    function automatic logic [15:0] m_sum();
        logic [15:0] b, o;
        b = base_sel ? base_val : pc_inc;
        case (off_sel)
            2'd1:    o = {{10{ir[5]}}, ir[5:0]};
            2'd2:    o = {{7{ir[8]}}, ir[8:0]};
            default: o = 16'h0000;
        endcase
        return b + o;
    endfunction

    function automatic logic m_taken();
        return (ir[11] & flag_n) | (ir[10] & flag_z) | (ir[9] & flag_p);
    endfunction

    function automatic logic [15:0] m_pc();
        case (pc_sel)
            2'd0:    return pc_inc;
            2'd1:    return m_taken() ? m_sum() : pc_inc;
            2'd2:    return m_sum();
            default: return bus_val;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply the current inputs, then check every output at the falling edge.
    task automatic run(string req);
        @(posedge clk);
        @(negedge clk);
        chk({req, " eff"}, eff_addr, m_sum());
        chk({req, " mar"}, mar_next, mar_sel ? {8'h00, ir[7:0]} : m_sum());
        chk({req, " br"}, 16'(br_taken), 16'(m_taken()));
        chk({req, " pc"}, pc_next, m_pc());
    endtask

    task automatic setv(logic [15:0] i, logic [15:0] p, logic [15:0] b,
                        logic bs, logic [1:0] os, logic ms, logic [1:0] ps);
        ir = i; pc_inc = p; base_val = b;
        base_sel = bs; off_sel = os; mar_sel = ms; pc_sel = ps;
    endtask

    initial begin
        ir = '0; pc_inc = '0; base_val = '0; bus_val = 16'hBEEF;
        flag_n = 0; flag_z = 1; flag_p = 0;
        base_sel = 0; off_sel = 0; mar_sel = 0; pc_sel = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // all-zero inputs: outputs settle to zero / pc_inc
        @(negedge clk);
        chk("R7 idle pc", pc_next, 16'h0000);
        chk("R3 idle eff", eff_addr, 16'h0000);
        // R1 PC-relative, most negative and most positive offsets
        setv(16'h0100, 16'h3000, 16'h0, 0, 2'd2, 0, 2'd2); run("R1 -256");
        chk("R1 -256 value", eff_addr, 16'h2F00);
        setv(16'h00FF, 16'h3000, 16'h0, 0, 2'd2, 0, 2'd2); run("R1 +255");
        chk("R1 +255 value", eff_addr, 16'h30FF);
        // R2 base+offset with -32 and +31
        setv(16'h0020, 16'h0, 16'h4000, 1, 2'd1, 0, 2'd0); run("R2 -32");
        chk("R2 -32 value", eff_addr, 16'h3FE0);
        setv(16'h001F, 16'h0, 16'h4000, 1, 2'd1, 0, 2'd0); run("R2 +31");
        chk("R2 +31 value", eff_addr, 16'h401F);
        // R3 / R9 register jump to any address, spare offset code too
        setv(16'hFFFF, 16'h1234, 16'hABCD, 1, 2'd0, 0, 2'd2); run("R9 jump");
        chk("R9 jump value", pc_next, 16'hABCD);
        setv(16'hFFFF, 16'h1234, 16'hABCD, 0, 2'd3, 0, 2'd0); run("R3 spare");
        chk("R3 spare value", eff_addr, 16'h1234);
        // R4 trap vector zero-extended, high bits of ir ignored
        setv(16'hF0A5, 16'h1111, 16'h0, 0, 2'd2, 1, 2'd3); run("R4 vec");
        chk("R4 vec value", mar_next, 16'h00A5);
        chk("R10 bus value", pc_next, 16'hBEEF);
        // R11 wrap below zero and above FFFF
        setv(16'h01FF, 16'h0000, 16'h0, 0, 2'd2, 0, 2'd1); run("R11 wrap");
        chk("R11 wrap value", eff_addr, 16'hFFFF);
        setv(16'h0001, 16'h0, 16'hFFFF, 1, 2'd1, 0, 2'd2); run("R11 wrap up");
        chk("R11 wrap up value", eff_addr, 16'h0000);
        // R5/R6/R8: every mask crossed with every single flag
        for (int m = 0; m < 8; m++) begin
            for (int f = 0; f < 3; f++) begin
                {flag_n, flag_z, flag_p} = 3'(1 << f);
                setv({4'h0, 3'(m), 9'h010}, 16'h3000, 16'h0, 0, 2'd2, 0, 2'd1);
                run("R5 mask");
                if (m == 0) chk("R6 never", 16'(br_taken), 16'h0);
                if (m == 7) chk("R6 always", 16'(br_taken), 16'h1);
                chk("R8 target", pc_next, m_taken() ? 16'h3010 : 16'h3000);
            end
        end
        // seeded random mix (R1..R11)
        void'($urandom(32'd2024));
        for (int k = 0; k < 3000; k++) begin
            ir = 16'($urandom); pc_inc = 16'($urandom); base_val = 16'($urandom);
            bus_val = 16'($urandom);
            {flag_n, flag_z, flag_p} = 3'($urandom);
            base_sel = 1'($urandom); off_sel = 2'($urandom);
            mar_sel = 1'($urandom); pc_sel = 2'($urandom);
            run("R1-R11 random");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule